// File: doc/BRIEF.md
# Teletext Packet Acquisition Sequencer

This block steps through one received data line of a teletext stream, starting right after the framing code has been found. It takes one byte each time the character-rate enable pulses. It Hamming-decodes the prefix bytes and checks the channel digits against programmed nibbles. It works out the packet length and decides, byte by byte, what goes to the buffer FIFO. The prefix layout is chosen from five types: long, medium and short DIDON, NABTS, and UK teletext. A mode without any prefix is also available.

In slow mode every qualifying line is stored. In fast mode nothing is stored until a page (or data-group) start has been recognised. The block then keeps a page-in-progress flag, which only the command reset clears. The output side is a byte with a one-cycle write strobe and a one-cycle end-of-packet pulse. All configuration arrives on static inputs. They must not change while a line is in progress.

Byte enables are assumed to be separated by at least one idle clock, because the character clock is one eighth of the bit clock. The first byte of a line follows the framing-code pulse by at least one clock.

Top module: `ttx_acq_seq`

## Requirements
- R1: A prefix byte with bits b7..b0 carries data nibble {b7,b5,b3,b1} (b7 most significant). The four checks are A=b7^b5^b1^b0, B=b7^b3^b2^b1, C=b5^b4^b3^b1, and D = XOR of all eight bits. With all four checks at 1 the byte is clean. With D=0, a single flipped bit is assumed: a flipped data bit is corrected and a flipped check bit is accepted as is. With D=1 and any of A, B, C at 0, the byte is rejected.
- R2: Each channel nibble (`cfg_dig1`, `cfg_dig2`, `cfg_dig3`) is compared with its decoded prefix nibble. A mismatch or a rejected byte abandons the line: no further write and no `pkt_done` until the next `line_start`. In UK mode only bits 2..0 of the first magazine/row nibble are compared with `cfg_dig1[2:0]`.
- R3: A decoded format code c maps to length c when c is below 4. Otherwise it maps to 4·(c−3)+`cfg_list` (0..3). List 0 therefore spans 4..48 and list 3 spans 7..51.
- R4: The packet length is `cfg_deflen` when `cfg_use_default` is 1 or the format byte is rejected. It is also `cfg_deflen` for medium DIDON, NABTS, UK and no-prefix lines.
- R5: `cfg_prefix` encodes 1=long DIDON (A1,A2,A3,CI,F), 2=medium DIDON (A1,A2), 3=short DIDON (A1,F), 4=NABTS (A1,A2,A3,CI,PS) and 5=UK (two magazine/row bytes); any other value selects no prefix. What is written, in order:
  - long DIDON: CI, F, then data;
  - medium DIDON: data only;
  - short DIDON: F, then data;
  - NABTS: CI, PS, then data;
  - UK: the two magazine/row bytes, then data;
  - no prefix: data only.
- R6: A written prefix byte has the accept flag in bit 7 (1 = accepted), with the remaining upper bits at 0. CI and PS sit in bits 3..0, the resolved length in bits 5..0, and the first UK byte's nibble in bits 3..0. The second UK byte holds the 5-bit row in bits 4..0, formed as {second nibble, bit 3 of the first nibble}; its flag is set only when both bytes were accepted.
- R7: With `cfg_fast`=1, nothing is written until the page flag is set. It is set in three cases:
  - UK: an accepted row-0 line;
  - NABTS: an accepted PS nibble with bit 0 set;
  - DIDON: a data byte whose low 7 bits are 0x1E directly after one whose low 7 bits are 0x01. Writing starts with the data byte after that pair.
  When the flag is set on a NABTS or UK line, that line's prefix bytes are written.
- R8: With `cfg_parity`=1, bit 7 of each data byte is stored as the XOR of all eight received bits (1 = odd parity good). With `cfg_parity`=0, data bytes are stored unchanged.
- R9: Exactly as many data bytes as the length are consumed. `pkt_done` pulses for one cycle together with the last one. With length 0 it pulses after the last prefix byte, or one clock after `line_start` when there is no prefix.
- R10: `cmd_reset` clears the page flag, drops any pending write and returns the block to idle.
- R11: After `rst_n` is released, `wr_en` and `pkt_done` are 0 and the page flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | Command reset: clears page flag, forces idle |
| line_start | input | 1 | Framing code found, start of a data line |
| byte_vld | input | 1 | Character-rate byte enable |
| byte_in | input | 8 | Received byte |
| cfg_prefix | input | 3 | Prefix type selector |
| cfg_fast | input | 1 | 1 = wait for page start before storing |
| cfg_parity | input | 1 | 1 = replace data bit 7 with odd-parity result |
| cfg_use_default | input | 1 | 1 = ignore format byte, use default length |
| cfg_list | input | 2 | Format list index |
| cfg_dig1 | input | 4 | First channel digit |
| cfg_dig2 | input | 4 | Second channel digit |
| cfg_dig3 | input | 4 | Third channel digit |
| cfg_deflen | input | LEN_W | Maximum/default packet length |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | FIFO write byte |
| pkt_done | output | 1 | End-of-packet pulse |

## Verification
The bench builds the block with its default `LEN_W` of 6. This makes every list entry up to 51 and default lengths up to 63 reachable. It also exercises the zero-length corner, where the end pulse follows the prefix directly. The default width keeps every line short enough that single-bit, check-bit and double-bit prefix corruptions, all four lists, and fast-mode gating across several consecutive lines can all be covered together.

// File: rtl/ttx_acq_pkg.sv
package ttx_acq_pkg;

  typedef enum logic [2:0] {
    PFX_NONE   = 3'd0,
    PFX_DLONG  = 3'd1,
    PFX_DMED   = 3'd2,
    PFX_DSHORT = 3'd3,
    PFX_NABTS  = 3'd4,
    PFX_UK     = 3'd5
  } pfx_t;

  typedef enum logic [3:0] {
    F_CH1, F_CH2, F_CH3, F_CI, F_FMT, F_PS, F_MR1, F_MR2, F_END
  } fld_t;

  typedef enum logic [1:0] {S_IDLE, S_PFX, S_DATA} st_t;

  localparam logic [6:0] SOH_CODE = 7'h01;
  localparam logic [6:0] RS_CODE  = 7'h1E;

  // Field order for each prefix layout
  function automatic fld_t field_at(input logic [2:0] p, input logic [2:0] k);
    fld_t f;
    f = F_END;
    case (p)
      PFX_DLONG:  case (k) 3'd0: f = F_CH1; 3'd1: f = F_CH2; 3'd2: f = F_CH3;
                           3'd3: f = F_CI;  3'd4: f = F_FMT; default: f = F_END; endcase
      PFX_DMED:   case (k) 3'd0: f = F_CH1; 3'd1: f = F_CH2; default: f = F_END; endcase
      PFX_DSHORT: case (k) 3'd0: f = F_CH1; 3'd1: f = F_FMT; default: f = F_END; endcase
      PFX_NABTS:  case (k) 3'd0: f = F_CH1; 3'd1: f = F_CH2; 3'd2: f = F_CH3;
                           3'd3: f = F_CI;  3'd4: f = F_PS;  default: f = F_END; endcase
      PFX_UK:     case (k) 3'd0: f = F_MR1; 3'd1: f = F_MR2; default: f = F_END; endcase
      default:    f = F_END;
    endcase
    return f;
  endfunction

  function automatic logic is_didon(input logic [2:0] p);
    return (p == PFX_DLONG) || (p == PFX_DMED) || (p == PFX_DSHORT);
  endfunction

endpackage

// File: rtl/ttx_hamm_dec.sv
module ttx_hamm_dec (
  input  logic [7:0] code,
  output logic       ok,
  output logic [3:0] nib
);
  logic ca, cb, cc, cd;
  logic [3:0] raw;

  always_comb begin
    ca  = code[7] ^ code[5] ^ code[1] ^ code[0];
    cb  = code[7] ^ code[3] ^ code[2] ^ code[1];
    cc  = code[5] ^ code[4] ^ code[3] ^ code[1];
    cd  = ^code;
    raw = {code[7], code[5], code[3], code[1]};
    nib = raw;
    ok  = 1'b1;
    if (cd) begin
      ok = ca & cb & cc;
    end else begin
      case ({ca, cb, cc})
        3'b001:  nib = raw ^ 4'b1000;
        3'b010:  nib = raw ^ 4'b0100;
        3'b100:  nib = raw ^ 4'b0010;
        3'b000:  nib = raw ^ 4'b0001;
        default: nib = raw;
      endcase
    end
  end
endmodule

// File: rtl/ttx_fmt_map.sv
module ttx_fmt_map #(
  parameter int LEN_W = 6
) (
  input  logic [3:0]       code,
  input  logic [1:0]       list,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    if (code < 4'd4) len = LEN_W'(code);
    else             len = LEN_W'({code - 4'd3, 2'b00}) + LEN_W'(list);
  end
endmodule

// File: rtl/ttx_acq_seq.sv
module ttx_acq_seq
  import ttx_acq_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_reset,
  input  logic             line_start,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic [2:0]       cfg_prefix,
  input  logic             cfg_fast,
  input  logic             cfg_parity,
  input  logic             cfg_use_default,
  input  logic [1:0]       cfg_list,
  input  logic [3:0]       cfg_dig1,
  input  logic [3:0]       cfg_dig2,
  input  logic [3:0]       cfg_dig3,
  input  logic [LEN_W-1:0] cfg_deflen,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             pkt_done
);

  st_t              st;
  logic [2:0]       k;
  logic [LEN_W-1:0] cnt, len_r;
  logic [7:0]       held, pend_byte;
  logic             pend_vld, page_flag, prev_soh;

  logic             h_ok;
  logic [3:0]       h_nib;
  logic [LEN_W-1:0] fmt_len;

  ttx_hamm_dec u_dec (.code(byte_in), .ok(h_ok), .nib(h_nib));
  ttx_fmt_map #(.LEN_W(LEN_W)) u_map (.code(h_nib), .list(cfg_list), .len(fmt_len));

  // Named events for the checker and the sequential logic
  fld_t             fld, fld_nx;
  logic             gate_open, chan_ok, pfx_done;
  logic             uk_start, nabts_start, didon_start;
  logic [4:0]       uk_row;
  logic [LEN_W-1:0] len_sel, len_go;
  logic [7:0]       data_st;

  always_comb begin
    fld         = field_at(cfg_prefix, k);
    fld_nx      = field_at(cfg_prefix, k + 3'd1);
    gate_open   = !cfg_fast || page_flag;
    uk_row      = {h_nib, held[3]};
    uk_start    = held[7] && h_ok && (uk_row == 5'd0);
    nabts_start = h_ok && h_nib[0];
    didon_start = is_didon(cfg_prefix) && prev_soh && (byte_in[6:0] == RS_CODE);
    len_sel     = (cfg_use_default || !h_ok) ? cfg_deflen : fmt_len;
    len_go      = (fld == F_FMT) ? len_sel : len_r;
    pfx_done    = (fld_nx == F_END);
    data_st     = cfg_parity ? {^byte_in, byte_in[6:0]} : byte_in;
    case (fld)
      F_CH1:   chan_ok = h_ok && (h_nib == cfg_dig1);
      F_CH2:   chan_ok = h_ok && (h_nib == cfg_dig2);
      F_CH3:   chan_ok = h_ok && (h_nib == cfg_dig3);
      F_MR1:   chan_ok = h_ok && (h_nib[2:0] == cfg_dig1[2:0]);
      default: chan_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; k <= '0; cnt <= '0; len_r <= '0;
      held <= '0; pend_byte <= '0; pend_vld <= 1'b0;
      page_flag <= 1'b0; prev_soh <= 1'b0;
      wr_en <= 1'b0; wr_data <= '0; pkt_done <= 1'b0;
    end else if (cmd_reset) begin
      st <= S_IDLE; pend_vld <= 1'b0; page_flag <= 1'b0;
      wr_en <= 1'b0; pkt_done <= 1'b0;
    end else begin
      wr_en    <= pend_vld;
      pkt_done <= 1'b0;
      pend_vld <= 1'b0;
      if (pend_vld) wr_data <= pend_byte;
      if (line_start) begin
        k <= '0; len_r <= cfg_deflen; prev_soh <= 1'b0; held <= '0;
        if (field_at(cfg_prefix, 3'd0) == F_END) begin
          cnt <= cfg_deflen;
          st  <= (cfg_deflen == '0) ? S_IDLE : S_DATA;
          if (cfg_deflen == '0) pkt_done <= 1'b1;
        end else begin
          st <= S_PFX;
        end
      end else if (byte_vld && st == S_PFX) begin
        case (fld)
          F_MR1: held <= {h_ok, 3'b000, h_nib};
          F_CI: begin
            if (cfg_prefix == PFX_NABTS) held <= {h_ok, 3'b000, h_nib};
            else if (gate_open) begin wr_en <= 1'b1; wr_data <= {h_ok, 3'b000, h_nib}; end
          end
          F_FMT: begin
            len_r <= len_sel;
            if (gate_open) begin wr_en <= 1'b1; wr_data <= {h_ok, 1'b0, 6'(len_sel)}; end
          end
          F_PS: begin
            if (nabts_start) page_flag <= 1'b1;
            if (gate_open || nabts_start) begin
              wr_en <= 1'b1; wr_data <= held;
              pend_vld <= 1'b1; pend_byte <= {h_ok, 3'b000, h_nib};
            end
          end
          F_MR2: begin
            if (uk_start) page_flag <= 1'b1;
            if (gate_open || uk_start) begin
              wr_en <= 1'b1; wr_data <= held;
              pend_vld <= 1'b1; pend_byte <= {held[7] & h_ok, 2'b00, uk_row};
            end
          end
          default: ;
        endcase
        if (!chan_ok) begin
          st <= S_IDLE;
        end else if (pfx_done) begin
          cnt <= len_go;
          st  <= (len_go == '0) ? S_IDLE : S_DATA;
          if (len_go == '0) pkt_done <= 1'b1;
        end else begin
          k <= k + 3'd1;
        end
      end else if (byte_vld && st == S_DATA) begin
        if (gate_open) begin wr_en <= 1'b1; wr_data <= data_st; end
        if (didon_start) page_flag <= 1'b1;
        prev_soh <= (byte_in[6:0] == SOH_CODE);
        cnt <= cnt - 1'b1;
        if (cnt == LEN_W'(1)) begin
          st <= S_IDLE; pkt_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ttx_acq_chk.sv
module ttx_acq_chk #(
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_reset,
  input logic             byte_vld,
  input logic             cfg_fast,
  input logic             wr_en,
  input logic             pkt_done,
  input logic             page_flag,
  input logic             pend_vld,
  input logic [LEN_W-1:0] fmt_len
);
  // R7: fast mode never writes while the page flag is clear
  a_r7_fast_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fast && !page_flag) |-> !wr_en);

  // R9: end-of-packet is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  // R10: command reset leaves nothing behind
  a_r10_cmd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!wr_en && !pkt_done && !page_flag && !pend_vld));

  // R5: a write always stems from a received byte or a held prefix byte
  a_r5_wr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(byte_vld) || $past(pend_vld)));

  // R3: the list lookup never exceeds the largest list entry
  a_r3_list_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_len <= LEN_W'(51));
endmodule

bind ttx_acq_seq ttx_acq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .byte_vld(byte_vld),
  .cfg_fast(cfg_fast), .wr_en(wr_en), .pkt_done(pkt_done),
  .page_flag(page_flag), .pend_vld(pend_vld), .fmt_len(fmt_len)
);

// File: tb/sim_ttx_acq_seq.sv
module sim_ttx_acq_seq;
  localparam int LEN_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_reset = 1'b0, line_start = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_in = '0;
  logic [2:0] cfg_prefix = '0;
  logic cfg_fast = 1'b0, cfg_parity = 1'b0, cfg_use_default = 1'b0;
  logic [1:0] cfg_list = '0;
  logic [3:0] cfg_dig1 = '0, cfg_dig2 = '0, cfg_dig3 = '0;
  logic [LEN_W-1:0] cfg_deflen = '0;
  logic wr_en, pkt_done;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  ttx_acq_seq #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .line_start(line_start),
    .byte_vld(byte_vld), .byte_in(byte_in), .cfg_prefix(cfg_prefix),
    .cfg_fast(cfg_fast), .cfg_parity(cfg_parity), .cfg_use_default(cfg_use_default),
    .cfg_list(cfg_list), .cfg_dig1(cfg_dig1), .cfg_dig2(cfg_dig2), .cfg_dig3(cfg_dig3),
    .cfg_deflen(cfg_deflen), .wr_en(wr_en), .wr_data(wr_data), .pkt_done(pkt_done)
  );

  int total = 0, bad = 0;
  int exp_done = 0, got_done = 0;
  logic [7:0] exp_q[$];
  string cur_tag = "R11";
  bit m_pif = 0;

  // Codeword search: data bits at b7,b5,b3,b1, all four checks at 1
  function automatic logic [7:0] enc(input logic [3:0] n);
    for (int r = 0; r < 16; r++) begin
      logic [7:0] w;
      w = {n[3], r[3], n[2], r[2], n[1], r[1], n[0], r[0]};
      if ((w[7]^w[5]^w[1]^w[0]) && (w[7]^w[3]^w[2]^w[1]) &&
          (w[5]^w[4]^w[3]^w[1]) && (^w)) return w;
    end
    return 8'h00;
  endfunction

  // Nearest-codeword decode: distance 0 or 1 accepted, otherwise rejected
  task automatic hdec(input logic [7:0] b, output logic ok, output logic [3:0] nb);
    int best = 9;
    nb = 4'd0;
    for (int n = 0; n < 16; n++) begin
      int d;
      d = $countones(b ^ enc(4'(n)));
      if (d < best) begin best = d; nb = 4'(n); end
    end
    ok = (best <= 1);
  endtask

  function automatic int list_len(input logic [3:0] c);
    if (c < 4) return int'(c);
    return (int'(c) - 3) * 4 + int'(cfg_list);
  endfunction

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: builds expected writes from the requirement text
  task automatic model(input logic [7:0] bs[$]);
    int ix = 0, len, fl[$];
    logic ok, mok;
    logic [3:0] nb, mnb;
    logic [7:0] hold, b;
    bit prev, open, st;
    len = int'(cfg_deflen); hold = 0; prev = 0; mok = 0; mnb = 0;
    case (cfg_prefix)
      3'd1: fl = '{1, 2, 3, 4, 5};
      3'd2: fl = '{1, 2};
      3'd3: fl = '{1, 5};
      3'd4: fl = '{1, 2, 3, 4, 6};
      3'd5: fl = '{7, 8};
      default: fl = {};
    endcase
    foreach (fl[i]) begin
      b = bs[ix]; ix++;
      hdec(b, ok, nb);
      open = !cfg_fast || m_pif;
      case (fl[i])
        1: if (!ok || nb != cfg_dig1) return;
        2: if (!ok || nb != cfg_dig2) return;
        3: if (!ok || nb != cfg_dig3) return;
        4: if (cfg_prefix == 3'd4) hold = {ok, 3'b0, nb};
           else if (open) exp_q.push_back({ok, 3'b0, nb});
        5: begin
             len = (ok && !cfg_use_default) ? list_len(nb) : int'(cfg_deflen);
             if (open) exp_q.push_back({ok, 1'b0, 6'(len)});
           end
        6: begin
             st = ok && nb[0];
             if (st) m_pif = 1;
             if (open || st) begin exp_q.push_back(hold); exp_q.push_back({ok, 3'b0, nb}); end
           end
        7: begin
             if (!ok || nb[2:0] != cfg_dig1[2:0]) return;
             mok = ok; mnb = nb;
           end
        8: begin
             st = mok && ok && (nb == 0) && !mnb[3];
             if (st) m_pif = 1;
             if (open || st) begin
               exp_q.push_back({mok, 3'b0, mnb});
               exp_q.push_back({mok && ok, 2'b0, nb, mnb[3]});
             end
           end
        default: ;
      endcase
    end
    for (int i = 0; i < len; i++) begin
      b = bs[ix]; ix++;
      if (!cfg_fast || m_pif)
        exp_q.push_back(cfg_parity ? {^b, b[6:0]} : b);
      if ((cfg_prefix inside {3'd1, 3'd2, 3'd3}) && prev && b[6:0] == 7'h1E) m_pif = 1;
      prev = (b[6:0] == 7'h01);
    end
    exp_done++;
  endtask

  task automatic run_line(input logic [7:0] bs[$], input string tag);
    cur_tag = tag;
    model(bs);
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
    foreach (bs[i]) begin
      byte_vld = 1'b1; byte_in = bs[i];
      @(negedge clk) byte_vld = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, {tag, " all expected writes seen"}, 0, exp_q.size());
    check(got_done == exp_done, {tag, " end-of-packet count"}, got_done, exp_done);
    exp_q.delete();
    got_done = exp_done;
  endtask

  task automatic data_bytes(inout logic [7:0] bs[$], input int n, input int seed);
    for (int i = 0; i < n; i++) bs.push_back(8'((i * 53 + seed * 17 + 3) & 255));
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (exp_q.size() == 0) check(1'b0, {cur_tag, " unexpected write"}, wr_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(wr_data == e, {cur_tag, " write data"}, wr_data, e);
        end
      end
      if (pkt_done) got_done++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] bs[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!wr_en && !pkt_done, "R11 reset outputs low", {wr_en, pkt_done}, 0);

    cfg_dig1 = 4'h3; cfg_dig2 = 4'hC; cfg_dig3 = 4'h6;

    // R5 R9 no prefix, plain data
    cfg_prefix = 3'd7; cfg_deflen = 6'd5;
    bs = {}; data_bytes(bs, 5, 1); run_line(bs, "R5_R9 no-prefix");
    // R8 parity replacement
    cfg_parity = 1'b1;
    bs = {}; data_bytes(bs, 5, 2); run_line(bs, "R8 parity");
    cfg_parity = 1'b0;
    // R9 zero length
    cfg_deflen = 6'd0;
    bs = {}; run_line(bs, "R9 zero-length");

    // R3 R5 R6 long DIDON, list 1, code 5 -> 9
    cfg_prefix = 3'd1; cfg_list = 2'd1; cfg_deflen = 6'd4;
    bs = {enc(4'h3), enc(4'hC), enc(4'h6), enc(4'hA), enc(4'h5)};
    data_bytes(bs, 9, 3); run_line(bs, "R3_R5_R6 long list1");
    // R3 list 3, code 15 -> 51
    cfg_list = 2'd3;
    bs = {enc(4'h3), enc(4'hC), enc(4'h6), enc(4'h1), enc(4'hF)};
    data_bytes(bs, 51, 4); run_line(bs, "R3 long list3 max");
    // R4 default select
    cfg_use_default = 1'b1; cfg_deflen = 6'd3;
    bs = {enc(4'h3), enc(4'hC), enc(4'h6), enc(4'h2), enc(4'h9)};
    data_bytes(bs, 3, 5); run_line(bs, "R4 default select");
    cfg_use_default = 1'b0;
    // R4 R6 rejected format byte (two bits flipped)
    bs = {enc(4'h3), enc(4'hC), enc(4'h6), enc(4'h2), enc(4'h9) ^ 8'h81};
    data_bytes(bs, 3, 6); run_line(bs, "R4_R6 rejected format");
    // R1 corrected data-bit and accepted check-bit errors in channel bytes
    cfg_list = 2'd0;
    bs = {enc(4'h3) ^ 8'h80, enc(4'hC) ^ 8'h40, enc(4'h6) ^ 8'h02, enc(4'h7) ^ 8'h01, enc(4'h4) ^ 8'h08};
    data_bytes(bs, 4, 7); run_line(bs, "R1 single errors");
    // R1 R2 double error in a channel byte abandons
    bs = {enc(4'h3) ^ 8'h06, enc(4'hC), enc(4'h6), enc(4'h1), enc(4'h2)};
    data_bytes(bs, 2, 8); run_line(bs, "R1_R2 double error");
    // R2 digit mismatch abandons
    bs = {enc(4'h3), enc(4'hD), enc(4'h6), enc(4'h1), enc(4'h2)};
    data_bytes(bs, 2, 9); run_line(bs, "R2 mismatch");

    // R5 medium and short DIDON
    cfg_prefix = 3'd2; cfg_deflen = 6'd6;
    bs = {enc(4'h3), enc(4'hC)}; data_bytes(bs, 6, 10); run_line(bs, "R5 medium");
    cfg_prefix = 3'd3; cfg_list = 2'd2;
    bs = {enc(4'h3), enc(4'h4)}; data_bytes(bs, 6, 11); run_line(bs, "R3_R5 short list2");

    // R2 R5 R6 UK slow: magazine compared on 3 bits only
    cfg_prefix = 3'd5; cfg_dig1 = 4'hB; cfg_deflen = 6'd4;
    bs = {enc(4'hB), enc(4'h9)}; data_bytes(bs, 4, 12); run_line(bs, "R2_R5_R6 UK slow");
    bs = {enc(4'h3), enc(4'h9)}; data_bytes(bs, 4, 13); run_line(bs, "R2 UK 3-bit compare");
    bs = {enc(4'h2), enc(4'h9)}; data_bytes(bs, 4, 14); run_line(bs, "R2 UK mismatch");

    // R7 UK fast: row 5 ignored, then row 0 opens
    cfg_fast = 1'b1;
    bs = {enc(4'hB), enc(4'h2)}; data_bytes(bs, 4, 15); run_line(bs, "R7 UK fast closed");
    bs = {enc(4'h3), enc(4'h0)}; data_bytes(bs, 4, 16); run_line(bs, "R7 UK row0 opens");
    bs = {enc(4'hB), enc(4'h7)}; data_bytes(bs, 4, 17); run_line(bs, "R7 UK stays open");

    // R10 command reset, then NABTS fast
    @(negedge clk) cmd_reset = 1'b1;
    @(negedge clk) cmd_reset = 1'b0;
    m_pif = 0;
    cfg_prefix = 3'd4; cfg_dig1 = 4'h3; cfg_deflen = 6'd5;
    bs = {enc(4'h3), enc(4'hC), enc(4'h6), enc(4'h8), enc(4'h2)};
    data_bytes(bs, 5, 18); run_line(bs, "R10 flag cleared");
    bs = {enc(4'h3), enc(4'hC), enc(4'h6), enc(4'h9), enc(4'h3)};
    data_bytes(bs, 5, 19); run_line(bs, "R7 NABTS start");
    bs = {enc(4'h3), enc(4'hC), enc(4'h6), enc(4'hA), enc(4'h4)};
    data_bytes(bs, 5, 20); run_line(bs, "R5_R7 NABTS open");

    // R7 DIDON fast: start pair inside the data
    @(negedge clk) cmd_reset = 1'b1;
    @(negedge clk) cmd_reset = 1'b0;
    m_pif = 0;
    cfg_prefix = 3'd2; cfg_deflen = 6'd8;
    bs = {enc(4'h3), enc(4'hC), 8'h55, 8'h81, 8'h1E, 8'h20, 8'h31, 8'h42, 8'h53, 8'h64};
    run_line(bs, "R7 DIDON start pair");
    bs = {enc(4'h3), enc(4'hC)}; data_bytes(bs, 8, 21); run_line(bs, "R7 DIDON open");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule